// File: doc/BRIEF.md
# Switch-Strobed Shift Register Board Demonstrator

This block is a top level for exercising a shift register by hand on a board. Three mechanical inputs, one push button and two toggle switches, each pass through their own conditioning channel. A channel brings the raw level into the clock domain with two flops. It then accepts a new level only after that level has stayed put for a programmable number of clock cycles. This removes contact bounce and short glitches.

The conditioned level of the data switch is the bit that enters the register. A shift happens once for each 0-to-1 change of the conditioned strobe switch. Releasing the button, which is the conditioned 1-to-0 change, loads a fixed constant into the register in one step. The eight register bits drive eight LED outputs directly, so an operator can clock in ones and zeros and watch them move toward the top bit. An asynchronous active-low reset clears everything. Its release is synchronised to the clock inside the block.

Top module: `switch_shift_demo`

## Requirements
- R1: After reset, all LED outputs are 0.
- R2: Each output led[i] shows register bit i, where bit 0 is the entry end and bit 7 is the oldest bit.
- R3: A raw input level is accepted only after it has been sampled unchanged on at least WAIT_CYCLES consecutive clock edges after the two-flop synchroniser. A pulse held for WAIT_CYCLES-1 cycles has no effect. A pulse held for exactly WAIT_CYCLES cycles is accepted.
- R4: The register shifts only when the conditioned strobe switch changes from 0 to 1. A 1-to-0 change of the strobe switch leaves the LEDs unchanged.
- R5: Each shift moves every bit up by one position, puts the conditioned data switch level into bit 0 and discards bit 7. Repeated shifts with the data switch on fill the LEDs with ones. With the switch off they fill the LEDs with zeros.
- R6: The conditioned 1-to-0 change of the button (its release) loads 8'hA5 into the register. Pressing the button has no effect.
- R7: When a load and a shift fall in the same cycle, only the load takes effect, and the LEDs show 8'hA5.
- R8: A strobe-switch change that the first clock edge samples shows on the LEDs at the (WAIT_CYCLES+3)-th rising edge, counting that first edge as edge 1. The LEDs are unchanged after edge WAIT_CYCLES+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release synchronised internally |
| btn_raw | input | 1 | Raw push button, 1 = pressed |
| sw_data_raw | input | 1 | Raw data switch, supplies the bit shifted in |
| sw_strobe_raw | input | 1 | Raw strobe switch, rising level triggers a shift |
| led | output | 8 | Register contents, one LED per bit |

## Verification
The shift path is driven first with a run of ones and then a run of zeros, which tells a correct entry end and direction apart from a mirrored or stuck register. A mixed bit sequence follows that a bench-side model predicts, and it exposes off-by-one shifts or a wrong data source. Each strobe is followed by its release, to separate a rising-edge trigger from a level or either-edge trigger. The button is checked with a press alone and then a release, and with a release that coincides with a strobe, which shows the load polarity and its priority. Pulses of WAIT_CYCLES-1 and WAIT_CYCLES cycles on the strobe and on the button, together with a cycle-exact latency probe, pin down the filter threshold and the pipeline depth.

// File: rtl/swdemo_pkg.sv
package swdemo_pkg;
  // conditioning channel assignment
  localparam int unsigned NUM_CH    = 3;
  localparam int unsigned CH_DATA   = 0;
  localparam int unsigned CH_STROBE = 1;
  localparam int unsigned CH_LOAD   = 2;

  // what a register update does in a given cycle
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } reg_op_e;
endpackage

// File: rtl/swdemo_rst_sync.sv
module swdemo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/swdemo_input_filter.sv
module swdemo_input_filter #(
  parameter int unsigned WAIT_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level
);
  localparam int unsigned CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic          meta_q;
  logic          sync_q;
  logic [CW-1:0] run_q, run_d;
  logic          level_q, level_d;
  logic          run_en;

  // two-flop synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
    end
  end

  // stability counter next state
  always_comb begin
    run_d   = run_q;
    level_d = level_q;
    run_en  = 1'b0;
    if (sync_q == level_q) begin
      run_en = (run_q != '0);
      run_d  = '0;
    end else if (run_q == LAST) begin
      run_en  = 1'b1;
      run_d   = '0;
      level_d = sync_q;
    end else begin
      run_en = 1'b1;
      run_d  = run_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (run_en) begin
      run_q   <= run_d;
      level_q <= level_d;
    end
  end

  assign level = level_q;

  AST_LEVEL_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(sync_q) == level_q)); // R3
  AST_LEVEL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(run_q) == LAST)); // R3
endmodule

// File: rtl/swdemo_edge_pulse.sv
module swdemo_edge_pulse #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = level & ~prev_q;
    end else begin : g_fall
      assign pulse = ~level & prev_q;
    end
  endgenerate

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R4
endmodule

// File: rtl/swdemo_shift_reg.sv
module swdemo_shift_reg
  import swdemo_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter logic [WIDTH-1:0] LOAD_VALUE = WIDTH'(8'hA5)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             strobe,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  reg_op_e          op;
  logic [WIDTH-1:0] q_q, q_d;
  logic             q_en;

  // load wins over a same-cycle strobe
  always_comb begin
    if (load)        op = OP_LOAD;
    else if (strobe) op = OP_SHIFT;
    else             op = OP_HOLD;
  end

  always_comb begin
    q_d  = q_q;
    q_en = 1'b0;
    case (op)
      OP_LOAD: begin
        q_d  = LOAD_VALUE;
        q_en = 1'b1;
      end
      OP_SHIFT: begin
        q_d  = {q_q[WIDTH-2:0], ser_in};
        q_en = 1'b1;
      end
      default: begin
        q_d  = q_q;
        q_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign q = q_q;

  AST_LOAD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == LOAD_VALUE)); // R6
  AST_SHIFT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !load) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_in)})); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !load) |=> $stable(q)); // R4
endmodule

// File: rtl/switch_shift_demo.sv
module switch_shift_demo
  import swdemo_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 10,
  parameter int unsigned WIDTH       = 8,
  parameter logic [WIDTH-1:0] LOAD_VALUE = WIDTH'(8'hA5)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_raw,
  input  logic             sw_data_raw,
  input  logic             sw_strobe_raw,
  output logic [WIDTH-1:0] led
);
  logic              rst_n_int;
  logic [NUM_CH-1:0] raw_vec;
  logic [NUM_CH-1:0] lvl_vec;
  logic              strobe_pulse;
  logic              load_pulse;

  swdemo_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_comb begin
    raw_vec            = '0;
    raw_vec[CH_DATA]   = sw_data_raw;
    raw_vec[CH_STROBE] = sw_strobe_raw;
    raw_vec[CH_LOAD]   = btn_raw;
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cond
      swdemo_input_filter #(.WAIT_CYCLES(WAIT_CYCLES)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n_int),
        .raw_in (raw_vec[ch]),
        .level  (lvl_vec[ch])
      );
    end
  endgenerate

  swdemo_edge_pulse #(.RISING(1'b1)) u_strobe_edge (
    .clk   (clk),
    .rst_n (rst_n_int),
    .level (lvl_vec[CH_STROBE]),
    .pulse (strobe_pulse)
  );

  swdemo_edge_pulse #(.RISING(1'b0)) u_release_edge (
    .clk   (clk),
    .rst_n (rst_n_int),
    .level (lvl_vec[CH_LOAD]),
    .pulse (load_pulse)
  );

  swdemo_shift_reg #(.WIDTH(WIDTH), .LOAD_VALUE(LOAD_VALUE)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load   (load_pulse),
    .strobe (strobe_pulse),
    .ser_in (lvl_vec[CH_DATA]),
    .q      (led)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_int) |-> (led == '0)); // R1
  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n_int)
    (load_pulse && strobe_pulse) |=> (led == LOAD_VALUE)); // R7
endmodule

// File: tb/switch_shift_demo_tb_top.sv
`timescale 1ns/1ps
module switch_shift_demo_tb_top;
  localparam int unsigned WAIT = 4;
  localparam logic [7:0]  PAT  = 8'hA5;

  logic       clk;
  logic       rst_n;
  logic       btn;
  logic       sw_d;
  logic       sw_s;
  logic [7:0] led;
  logic [7:0] model;
  int         n_cmp;
  int         n_bad;
  bit         done;

  switch_shift_demo #(.WAIT_CYCLES(WAIT), .WIDTH(8), .LOAD_VALUE(PAT)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .btn_raw       (btn),
    .sw_data_raw   (sw_d),
    .sw_strobe_raw (sw_s),
    .led           (led)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one full strobe: settle data, raise strobe, check shift, lower strobe, check hold
  task automatic strobe_bit(input logic b);
    sw_d = b;
    tick(WAIT + 4);
    sw_s = 1'b1;
    tick(WAIT + 4);
    model = {model[6:0], b};
    chk(led, model, "R5");
    sw_s = 1'b0;
    tick(WAIT + 4);
    chk(led, model, "R4");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; btn = 1'b0; sw_d = 1'b0; sw_s = 1'b0;
    model = '0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    chk(led, 8'h00, "R1");

    // fill with ones, then zeros
    for (int i = 0; i < 8; i++) strobe_bit(1'b1);
    chk(led, 8'hFF, "R5");
    for (int i = 0; i < 8; i++) strobe_bit(1'b0);
    chk(led, 8'h00, "R5");
    // mixed sequence
    for (int i = 0; i < 12; i++) strobe_bit(((i * 3) % 5) > 1);

    // R8: latency of a strobe
    sw_d = 1'b1;
    tick(WAIT + 4);
    sw_s = 1'b1;
    tick(WAIT + 2);
    chk(led, model, "R8");
    tick(1);
    model = {model[6:0], 1'b1};
    chk(led, model, "R8");
    sw_s = 1'b0;
    tick(WAIT + 4);

    // R3: short strobe glitch ignored, exact-length pulse accepted
    sw_s = 1'b1;
    tick(WAIT - 1);
    sw_s = 1'b0;
    tick(WAIT + 6);
    chk(led, model, "R3");
    sw_d = 1'b0;
    tick(WAIT + 4);
    sw_s = 1'b1;
    tick(WAIT);
    sw_s = 1'b0;
    tick(WAIT + 6);
    model = {model[6:0], 1'b0};
    chk(led, model, "R3");

    // R3: short button glitch ignored
    btn = 1'b1;
    tick(WAIT - 1);
    btn = 1'b0;
    tick(WAIT + 6);
    chk(led, model, "R3");

    // R6: press alone no effect, release loads
    btn = 1'b1;
    tick(WAIT + 4);
    chk(led, model, "R6");
    btn = 1'b0;
    tick(WAIT + 4);
    model = PAT;
    chk(led, PAT, "R6");
    for (int i = 0; i < 8; i++) chk({7'd0, led[i]}, {7'd0, PAT[i]}, "R2");

    // shift away from the pattern, then coincide load with strobe
    strobe_bit(1'b1);
    strobe_bit(1'b1);
    btn = 1'b1;
    tick(WAIT + 4);
    btn = 1'b0;
    sw_s = 1'b1;
    tick(WAIT + 4);
    model = PAT;
    chk(led, PAT, "R7");
    sw_s = 1'b0;
    tick(WAIT + 4);
    chk(led, PAT, "R7");

    // continue shifting after load
    strobe_bit(1'b0);
    strobe_bit(1'b1);

    // R1: reset again clears
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(4);
    chk(led, 8'h00, "R1");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule